// File: doc/BRIEF.md
# Descriptor-Fetching Multi-Channel Memory Copy Engine

This block copies blocks of 32-bit words from one memory region to another on behalf of several independent channels. Software never hands the engine its source, destination or length directly. It writes the memory address of a four-word descriptor into a channel register and then sets that channel's start bit. The engine fetches the descriptor over its own memory master port and then performs the copy one word at a time. When the copy is done, it marks the channel finished.

Each finished channel raises a completion flag. All flags are also gathered into one global status word. The low channels each drive a dedicated interrupt line. Every channel above them shares a single common line. One mover serves all channels and runs one transfer to its end before it takes the next. When several channels are waiting, the lowest-numbered one goes first.

Top module: `dma_cb_engine`

## Requirements
- R1: After reset, every channel's control/status word, the global status word and all interrupt outputs read as zero.
- R2: Register address bits [11:8] select the channel. Offset 0x00 is control/status, with bit 0 = busy/start and bit 2 = done flag. Offset 0x04 is the descriptor address, and it reads back what was written. Address 0xFE0 returns the global status word, with bit n = channel n's done flag.
- R3: Writing control/status with bit 0 set on an idle channel starts it. The engine reads four words at the descriptor address, +4, +8 and +12: word 0 = transfer options, word 1 = source address, word 2 = destination address, word 3 = length in bytes.
- R4: The copy moves length/4 words, ignoring the two low length bits. Each word is read from the source and written to the destination. Option bit 8 advances the source by 4 per word and option bit 4 advances the destination by 4 per word. An address whose bit is clear stays fixed.
- R5: When the last word is written, the channel's busy bit clears and its done flag sets. This also sets bit n of the global status word.
- R6: Writing control/status with bit 2 set clears the done flag and its global status bit. Writing control/status with bit 0 clear to an idle channel starts nothing and changes nothing.
- R7: For channel i below N_DED, irq[i] is high while the channel's done flag is set and option bit 0 of its last descriptor was set. irq[N_DED] is the OR of that condition over all channels from N_DED upward.
- R8: Only one channel's transfer runs at a time, and it runs to completion. When the mover is free, the lowest-numbered busy channel is served first, whatever order the channels were started in.
- R9: A descriptor length below 4 completes the channel right after the descriptor fetch, with no data write.
- R10: The master port keeps mem_req high, and mem_addr, mem_we and mem_wdata stable, from the start of a request until the cycle mem_ack is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Memory access accepted / completed |
| irq | output | N_DED+1 | Dedicated lines [N_DED-1:0], shared line [N_DED] |

## Verification
The bench builds the engine with N_CH = 4 and N_DED = 2. With these values, two channels sit on dedicated interrupt lines and two share the common line, so both interrupt paths and the OR merge on the shared line can be reached with a handful of transfers. Four channels are also enough to start a high channel and then two lower ones while the mover is busy. This shows that service order follows channel number and not start order. The short transfers include partial lengths and fixed-address cases.

// File: rtl/dma_cb_pkg.sv
package dma_cb_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned RADDR_W = 12;

  localparam logic [7:0]         OFS_CTRL  = 8'h00;
  localparam logic [7:0]         OFS_DESC  = 8'h04;
  localparam logic [RADDR_W-1:0] ADR_GSTAT = 12'hFE0;

  localparam int BIT_BUSY  = 0;
  localparam int BIT_DONE  = 2;
  localparam int OPT_IRQEN = 0;
  localparam int OPT_DSTEP = 4;
  localparam int OPT_SSTEP = 8;

  typedef enum logic [2:0] {
    MV_IDLE, MV_FETCH, MV_READ, MV_WRITE, MV_FINISH
  } mv_state_t;

  function automatic logic [WORD_W-1:0] step_addr(input logic [WORD_W-1:0] a,
                                                  input logic adv);
    return adv ? a + 32'd4 : a;
  endfunction

  function automatic logic [WORD_W-3:0] words_of(input logic [WORD_W-1:0] len);
    return len[WORD_W-1:2];
  endfunction

  function automatic logic [WORD_W-1:0] desc_word_addr(input logic [WORD_W-1:0] base,
                                                       input logic [1:0] idx);
    return base + {28'd0, idx, 2'b00};
  endfunction
endpackage

// File: rtl/dma_cb_chan.sv
module dma_cb_chan
  import dma_cb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              wr_desc,
  input  logic [WORD_W-1:0] wdata,
  input  logic              fin,
  input  logic              fin_irqen,
  output logic              busy,
  output logic              done_flag,
  output logic              irq_en,
  output logic [WORD_W-1:0] desc_addr
);
  logic start_req, clear_req;
  assign start_req = wr_ctrl && wdata[BIT_BUSY] && !busy;
  assign clear_req = wr_ctrl && wdata[BIT_DONE];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      done_flag <= 1'b0;
      irq_en    <= 1'b0;
      desc_addr <= '0;
    end else begin
      if (fin) begin
        busy      <= 1'b0;
        done_flag <= 1'b1;
        irq_en    <= fin_irqen;
      end else begin
        if (start_req) busy <= 1'b1;
        if (clear_req) done_flag <= 1'b0;
      end
      if (wr_desc) desc_addr <= wdata;
    end
  end
endmodule

// File: rtl/dma_cb_arb.sv
module dma_cb_arb #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant,
  output logic         any
);
  assign grant = req & (~req + {{(N-1){1'b0}}, 1'b1});
  assign any   = |req;
endmodule

// File: rtl/dma_cb_mover.sv
module dma_cb_mover
  import dma_cb_pkg::*;
#(
  parameter int unsigned N_CH = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [N_CH-1:0]              grant,
  input  logic                         any_busy,
  input  logic [N_CH-1:0][WORD_W-1:0]  desc_vec,
  output logic [N_CH-1:0]              fin_vec,
  output logic                         fin_irqen,
  output logic                         mem_req,
  output logic                         mem_we,
  output logic [WORD_W-1:0]            mem_addr,
  output logic [WORD_W-1:0]            mem_wdata,
  input  logic [WORD_W-1:0]            mem_rdata,
  input  logic                         mem_ack
);
  mv_state_t         st;
  logic [N_CH-1:0]   owner;
  logic [1:0]        fidx;
  logic [WORD_W-1:0] opts, src, dst, hold;
  logic [WORD_W-3:0] left;
  logic [WORD_W-1:0] desc_sel;

  always_comb begin
    desc_sel = '0;
    for (int i = 0; i < int'(N_CH); i++)
      if (owner[i]) desc_sel = desc_sel | desc_vec[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= MV_IDLE; owner <= '0; fidx <= '0;
      opts <= '0; src <= '0; dst <= '0; hold <= '0; left <= '0;
    end else begin
      unique case (st)
        MV_IDLE: if (any_busy) begin
          owner <= grant; fidx <= 2'd0; st <= MV_FETCH;
        end
        MV_FETCH: if (mem_ack) begin
          fidx <= fidx + 2'd1;
          unique case (fidx)
            2'd0: opts <= mem_rdata;
            2'd1: src  <= mem_rdata;
            2'd2: dst  <= mem_rdata;
            default: begin
              left <= words_of(mem_rdata);
              st   <= (words_of(mem_rdata) == '0) ? MV_FINISH : MV_READ;
            end
          endcase
        end
        MV_READ: if (mem_ack) begin
          hold <= mem_rdata; st <= MV_WRITE;
        end
        MV_WRITE: if (mem_ack) begin
          src  <= step_addr(src, opts[OPT_SSTEP]);
          dst  <= step_addr(dst, opts[OPT_DSTEP]);
          left <= left - 1'b1;
          st   <= (left == 1) ? MV_FINISH : MV_READ;
        end
        default: st <= MV_IDLE;
      endcase
    end
  end

  assign fin_vec   = (st == MV_FINISH) ? owner : '0;
  assign fin_irqen = opts[OPT_IRQEN];
  assign mem_req   = (st == MV_FETCH) || (st == MV_READ) || (st == MV_WRITE);
  assign mem_we    = (st == MV_WRITE);
  assign mem_wdata = hold;
  always_comb begin
    unique case (st)
      MV_FETCH: mem_addr = desc_word_addr(desc_sel, fidx);
      MV_READ:  mem_addr = src;
      MV_WRITE: mem_addr = dst;
      default:  mem_addr = '0;
    endcase
  end
endmodule

// File: rtl/dma_cb_engine.sv
module dma_cb_engine
  import dma_cb_pkg::*;
#(
  parameter int unsigned N_CH  = 4,
  parameter int unsigned N_DED = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [11:0]       reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [31:0]       mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_ack,
  output logic [N_DED:0]    irq
);
  localparam int unsigned N_SHR = N_CH - N_DED;

  logic [N_CH-1:0]             active_vec, int_vec, irqen_vec, done_vec, grant, raised;
  logic [N_CH-1:0][WORD_W-1:0] desc_vec;
  logic                        any_busy, fin_irqen;
  logic [3:0]                  sel_ch;
  logic [7:0]                  sel_ofs;

  assign sel_ch  = reg_addr[11:8];
  assign sel_ofs = reg_addr[7:0];

  for (genvar c = 0; c < int'(N_CH); c++) begin : g_ch
    logic hit;
    assign hit = reg_wr && (sel_ch == 4'(c));
    dma_cb_chan u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_ctrl   (hit && (sel_ofs == OFS_CTRL)),
      .wr_desc   (hit && (sel_ofs == OFS_DESC)),
      .wdata     (reg_wdata),
      .fin       (done_vec[c]),
      .fin_irqen (fin_irqen),
      .busy      (active_vec[c]),
      .done_flag (int_vec[c]),
      .irq_en    (irqen_vec[c]),
      .desc_addr (desc_vec[c])
    );
  end

  dma_cb_arb #(.N(N_CH)) u_arb (.req(active_vec), .grant(grant), .any(any_busy));

  dma_cb_mover #(.N_CH(N_CH)) u_mover (
    .clk(clk), .rst_n(rst_n), .grant(grant), .any_busy(any_busy),
    .desc_vec(desc_vec), .fin_vec(done_vec), .fin_irqen(fin_irqen),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  assign raised = int_vec & irqen_vec;
  assign irq[N_DED-1:0] = raised[N_DED-1:0];
  assign irq[N_DED]     = |raised[N_CH-1:N_CH-N_SHR];

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADR_GSTAT) begin
      reg_rdata[N_CH-1:0] = int_vec;
    end else begin
      for (int c = 0; c < int'(N_CH); c++) begin
        if (sel_ch == 4'(c)) begin
          if (sel_ofs == OFS_CTRL) begin
            reg_rdata[BIT_BUSY] = active_vec[c];
            reg_rdata[BIT_DONE] = int_vec[c];
          end else if (sel_ofs == OFS_DESC) begin
            reg_rdata = desc_vec[c];
          end
        end
      end
    end
  end
endmodule

// File: rtl/dma_cb_checker.sv
module dma_cb_checker #(
  parameter int unsigned N_CH  = 4,
  parameter int unsigned N_DED = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            mem_req,
  input logic            mem_we,
  input logic            mem_ack,
  input logic [31:0]     mem_addr,
  input logic [31:0]     mem_wdata,
  input logic [N_CH-1:0] done_vec,
  input logic [N_CH-1:0] int_vec,
  input logic [N_CH-1:0] active_vec,
  input logic [N_DED:0]  irq
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R10

  AST_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(done_vec)); // R8

  AST_FIN_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (done_vec != '0) |=> ((int_vec & $past(done_vec)) == $past(done_vec))); // R5

  AST_FIN_DROPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (done_vec != '0) |=> ((active_vec & $past(done_vec)) == '0)); // R5

  AST_FIN_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ((done_vec & ~active_vec) == '0)); // R8

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (irq != '0) |-> (int_vec != '0)); // R7
endmodule

bind dma_cb_engine dma_cb_checker #(.N_CH(N_CH), .N_DED(N_DED)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .done_vec(done_vec),
  .int_vec(int_vec), .active_vec(active_vec), .irq(irq)
);

// File: tb/test_dma_cb_engine.sv
module test_dma_cb_engine;
  localparam int NC = 4;
  localparam int ND = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [ND:0] irq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [31:0] mem [256];
  logic [63:0] expq [$];

  always #10 clk = ~clk;

  dma_cb_engine #(.N_CH(NC), .N_DED(ND)) i_dma_cb_engine (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .irq(irq)
  );

  // memory model: one-cycle registered ack
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0; mem_rdata <= '0;
    end else if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[9:2]];
    end else begin
      mem_ack <= 1'b0;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: scoreboard of data writes, plus handshake stability (R10)
  logic        pend_prev = 1'b0;
  logic [31:0] addr_prev = '0;
  int          hs_bad = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (pend_prev && !(mem_req && mem_addr == addr_prev)) hs_bad++;
      pend_prev <= mem_req && !mem_ack;
      addr_prev <= mem_addr;
      if (mem_req && mem_we && mem_ack) begin
        if (expq.size() == 0) begin
          checks++; errors++;
          $display("FAIL R9/R4 unexpected write: actual %h@%h expected none", mem_wdata, mem_addr);
        end else begin
          logic [63:0] e;
          e = expq.pop_front();
          chk("R4 write address", mem_addr, e[63:32]);
          chk("R4 write data", mem_wdata, e[31:0]);
        end
      end
    end
  end

  task automatic rwrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rread(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  // driver: lays out descriptor and source, pushes expected writes
  task automatic prep(input int ch, input int cb, input logic [31:0] opt,
                      input int src, input int dst, input int len, input logic [31:0] seed);
    int nw;
    nw = len / 4;
    mem[cb/4] = opt; mem[cb/4+1] = src; mem[cb/4+2] = dst; mem[cb/4+3] = len;
    for (int k = 0; k < nw; k++) begin
      logic [31:0] v, da;
      v  = opt[8] ? (seed ^ (32'h0101_0101 * k)) : seed;
      if (opt[8] || k == 0) mem[src/4 + k] = v;
      da = opt[4] ? dst + 4 * k : dst;
      expq.push_back({da, v});
    end
    rwrite(12'(ch * 256 + 4), cb);
  endtask

  task automatic drain();
    while (expq.size() != 0) @(negedge clk);
    repeat (10) @(negedge clk);
  endtask

  initial begin
    logic [31:0] r;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    rread(12'h000, r); chk("R1 ctrl ch0", r, 0);
    rread(12'h300, r); chk("R1 ctrl ch3", r, 0);
    rread(12'hFE0, r); chk("R1 gstat", r, 0);
    chk("R1 irq", 32'(irq), 0);

    // R2 descriptor address readback
    rwrite(12'h104, 32'h0000_01A0);
    rread(12'h104, r); chk("R2 desc addr ch1", r, 32'h1A0);
    rread(12'h004, r); chk("R2 desc addr ch0 untouched", r, 0);

    // R3/R4/R5/R7: ch0, both steps, irq enabled, 8 words
    prep(0, 32'h100, 32'h111, 32'h020, 32'h040, 32, 32'h1234_5678);
    rwrite(12'h000, 32'h1);
    rread(12'h000, r); chk("R3 busy after start", r, 32'h1);
    drain();
    rread(12'h000, r); chk("R5 ctrl after done", r, 32'h4);
    rread(12'hFE0, r); chk("R5 gstat bit0", r, 32'h1);
    chk("R7 dedicated irq0", 32'(irq), 32'h1);
    rwrite(12'h000, 32'h4);
    rread(12'h000, r); chk("R6 ctrl cleared", r, 0);
    rread(12'hFE0, r); chk("R6 gstat cleared", r, 0);
    chk("R7 irq after clear", 32'(irq), 0);

    // R4: ch1, source steps, fixed destination, no irq, 14 bytes -> 3 words
    prep(1, 32'h180, 32'h100, 32'h0A0, 32'h0F0, 14, 32'hCAFE_0000);
    rwrite(12'h100, 32'h1);
    drain();
    rread(12'hFE0, r); chk("R5 gstat bit1", r, 32'h2);
    chk("R7 irq stays low without enable", 32'(irq), 0);
    rwrite(12'h100, 32'h4);

    // R7 shared line from ch3
    prep(3, 32'h200, 32'h111, 32'h300, 32'h340, 8, 32'h5A5A_0001);
    rwrite(12'h300, 32'h1);
    drain();
    chk("R7 shared irq ch3", 32'(irq), 32'h4);
    rwrite(12'h300, 32'h4);
    chk("R7 shared irq cleared", 32'(irq), 0);

    // R8 priority: ch3 running, then ch2 and ch0 started; ch0 must precede ch2
    prep(3, 32'h200, 32'h110, 32'h300, 32'h340, 16, 32'h3333_0000);
    rwrite(12'h300, 32'h1);
    prep(0, 32'h100, 32'h111, 32'h020, 32'h040, 8, 32'h0000_AAAA);
    prep(2, 32'h280, 32'h111, 32'h380, 32'h3C0, 8, 32'h2222_BBBB);
    rwrite(12'h200, 32'h1);
    rwrite(12'h000, 32'h1);
    drain();
    rread(12'hFE0, r); chk("R8 all three done", r, 32'hD);
    chk("R8 irq lines", 32'(irq), 32'h5);
    rwrite(12'h000, 32'h4); rwrite(12'h200, 32'h4); rwrite(12'h300, 32'h4);
    rread(12'hFE0, r); chk("R6 gstat after clears", r, 0);

    // R9 zero-length descriptor
    prep(2, 32'h280, 32'h111, 32'h380, 32'h3C0, 3, 32'h0);
    rwrite(12'h200, 32'h1);
    drain();
    rread(12'h200, r); chk("R9 zero length done", r, 32'h4);
    rwrite(12'h200, 32'h4);

    // R6 writing 0 to idle ctrl starts nothing
    rwrite(12'h000, 32'h0);
    repeat (20) @(negedge clk);
    rread(12'h000, r); chk("R6 idle zero write ctrl", r, 0);
    rread(12'hFE0, r); chk("R6 idle zero write gstat", r, 0);
    chk("R6 no memory traffic", 32'(mem_req), 0);

    chk("R10 handshake stable", hs_bad, 0);
    chk("R4 scoreboard empty", expq.size(), 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule